// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block collects interrupt requests from 29 peripheral lines and 4 exception (trap) lines. It keeps a pending flag, an enable bit and a 3-bit priority for each peripheral source. It then picks the strongest eligible request and compares its level with the current CPU priority level. When the request wins, the block raises a one-cycle acknowledge to the core. The acknowledge carries a vector number and the word address of that vector's table slot. On acceptance the old CPU level goes onto an 8-entry stack, and a return pulse restores it.

Software reaches the block through a 16-word register window:

- Three words hold the pending flags.
- Three words hold the enables.
- Eight words hold the priorities.
- One control word holds the nesting-disable bit, the window-active status bit, the alternate-table select and the CPU level.
- One word loads a countdown that masks levels 6 and below for a number of retired instructions.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the CPU level is 0, no acknowledge is raised, and every flag, enable, priority and control bit reads 0.
- R2: Register words 0..2 hold the pending flags; source i sits in word i/16, bit i%16. A request pulse sets the flag whether or not the source is enabled. A register write replaces the stored bits, and a request arriving in the same cycle wins.
- R3: Words 3..5 hold the enables, with the same bit layout as the flags. Words 6..13 hold the priorities; source i sits in word 6+i/4, bits 4*(i%4)+2 down to 4*(i%4). A source is eligible only when it is flagged, enabled and its priority is non-zero, so priority 0 never fires.
- R4: A request is accepted only when its level is strictly greater than the CPU level. Acceptance raises the acknowledge for exactly one cycle, one clock after the deciding cycle. Source i reports vector 8+i and trap t reports vector t.
- R5: Among eligible sources the highest priority wins, and ties go to the lowest vector. Pending traps outrank every maskable source; trap t runs at level 11-t, so the lowest-numbered trap wins. A trap's pending bit clears when the trap is accepted.
- R6: The vector address is the table base plus twice the vector number. The base is 0x000004, or 0x000084 when control word 14 bit 13 is set.
- R7: Acceptance pushes the old CPU level and loads the winner's level. A return pulse pops the previous level and suppresses acceptance in that cycle. A return pulse with an empty stack changes nothing.
- R8: While control bit 15 (nesting disable) is set and at least one interrupt is in service, no maskable request is accepted, whatever its priority. Traps are still accepted.
- R9: While control bit 15 is set, writes to the CPU level field (control bits 3:0) are ignored. When the bit is clear, writes take effect.
- R10: A write to word 15 loads the window counter, restarting any window in progress. Each retire strobe decrements a non-zero count. Control bit 14 reads 1 while the count is non-zero. During the window only level-7 sources and traps are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 29 | Peripheral request pulses, one per source |
| trap_req | input | 4 | Trap request pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| retire | input | 1 | One instruction retired |
| iret | input | 1 | Return from interrupt |
| int_ack | output | 1 | One-cycle acceptance strobe |
| int_vec | output | 6 | Accepted vector number |
| int_addr | output | 24 | Word address of the vector's table slot |
| cpu_level | output | 4 | Current CPU priority level |

## Verification
The assertions watch, on every cycle, that an acknowledge always raises the CPU level and that a return pops exactly one stack entry. They also check that nesting disable admits only traps while an interrupt is in service, that the level stays frozen under nesting disable except when an interrupt is accepted, and that only level 7 and above is taken during a disable window.

The bench scenarios cover the behaviour that depends on choice and data rather than on an invariant. That includes the tie-breaking order, the vector numbers and table addresses, priority 0 silencing an enabled source, flags latching while disabled, the window reload restart, and stacked levels coming back in the right order.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NSRC  = 29,
  parameter int NTRAP = 4,
  parameter int DEPTH = 8,
  parameter int CNTW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic [NTRAP-1:0]  trap_req,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              retire,
  input  logic              iret,
  output logic              int_ack,
  output logic [5:0]        int_vec,
  output logic [23:0]       int_addr,
  output logic [3:0]        cpu_level
);
  localparam int SW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [NSRC-1:0]  flag_q, flag_d, en_q, en_d;
  logic [2:0]       prio_q [NSRC];
  logic [2:0]       prio_d [NSRC];
  logic [NTRAP-1:0] trap_q, trap_clr;
  logic [3:0]       lvl_q;
  logic [3:0]       stk_q [DEPTH];
  logic [SW-1:0]    dep_q;
  logic             nest_q, alt_q, ack_q;
  logic [5:0]       vec_q;
  logic [CNTW-1:0]  win_q;

  wire win_on  = win_q != '0;
  wire ctrl_wr = reg_wr && reg_addr == 4'd14;

  always_comb begin
    flag_d = flag_q;
    en_d   = en_q;
    prio_d = prio_q;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_wr && reg_addr == 4'(i / 16))     flag_d[i] = reg_wdata[i % 16];
      if (irq_req[i])                           flag_d[i] = 1'b1;
      if (reg_wr && reg_addr == 4'(3 + i / 16)) en_d[i]   = reg_wdata[i % 16];
      if (reg_wr && reg_addr == 4'(6 + i / 4))  prio_d[i] = reg_wdata[4*(i%4) +: 3];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_addr == 4'(i / 16))     reg_rdata[i % 16] = flag_q[i];
      if (reg_addr == 4'(3 + i / 16)) reg_rdata[i % 16] = en_q[i];
      if (reg_addr == 4'(6 + i / 4))  reg_rdata[4*(i%4) +: 3] = prio_q[i];
    end
    if (reg_addr == 4'd14) reg_rdata = {nest_q, win_on, alt_q, 9'd0, lvl_q};
    if (reg_addr == 4'd15) reg_rdata = 16'(win_q);
  end

  logic [2:0] best_p;
  logic [5:0] best_i, tr_i, cand_vec;
  logic       tr_ok;
  logic [3:0] cand_lvl;

  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++)
      if (flag_q[i] && en_q[i] && prio_q[i] > best_p) begin
        best_p = prio_q[i];
        best_i = 6'(i);
      end
    tr_ok = 1'b0;
    tr_i  = '0;
    for (int t = NTRAP - 1; t >= 0; t--)
      if (trap_q[t]) begin
        tr_ok = 1'b1;
        tr_i  = 6'(t);
      end
  end

  assign cand_lvl = tr_ok ? 4'd11 - tr_i[3:0] : {1'b0, best_p};
  assign cand_vec = tr_ok ? tr_i : 6'd8 + best_i;

  wire masked = (nest_q && dep_q != '0) || (win_on && best_p != 3'd7);
  wire accept = !iret && dep_q != SW'(DEPTH) && (tr_ok || best_p != '0)
                && cand_lvl > lvl_q && (tr_ok || !masked);
  assign trap_clr = (accept && tr_ok) ? NTRAP'(1) << tr_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      prio_q <= '{default: '0};
      trap_q <= '0;
      lvl_q  <= '0;
      stk_q  <= '{default: '0};
      dep_q  <= '0;
      nest_q <= 1'b0;
      alt_q  <= 1'b0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
      win_q  <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      prio_q <= prio_d;
      trap_q <= (trap_q & ~trap_clr) | trap_req;
      ack_q  <= accept;
      if (accept) vec_q <= cand_vec;
      if (iret && dep_q != '0) begin
        lvl_q <= stk_q[PW'(dep_q - SW'(1))];
        dep_q <= dep_q - SW'(1);
      end else if (accept) begin
        stk_q[dep_q[PW-1:0]] <= lvl_q;
        dep_q <= dep_q + SW'(1);
        lvl_q <= cand_lvl;
      end else if (ctrl_wr && !nest_q) begin
        lvl_q <= reg_wdata[3:0];
      end
      if (ctrl_wr) begin
        nest_q <= reg_wdata[15];
        alt_q  <= reg_wdata[13];
      end
      if (reg_wr && reg_addr == 4'd15) win_q <= reg_wdata[CNTW-1:0];
      else if (retire && win_on)       win_q <= win_q - CNTW'(1);
    end
  end

  assign int_ack   = ack_q;
  assign int_vec   = vec_q;
  assign int_addr  = (alt_q ? 24'h000084 : 24'h000004) + {17'd0, vec_q, 1'b0};
  assign cpu_level = lvl_q;

  a_r4_ack_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> cpu_level > $past(cpu_level));
  a_r7_return_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (iret && dep_q != '0) |=> dep_q == $past(dep_q) - SW'(1));
  a_r8_nest_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_q && dep_q != '0 && trap_q == '0) |=> (!int_ack || int_vec < 6'(NTRAP)));
  a_r9_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_q && !iret) |=> (int_ack || cpu_level == $past(cpu_level)));
  a_r10_window_mask: assert property (@(posedge clk) disable iff (!rst_n)
    win_on |=> (!int_ack || cpu_level >= 4'd7));
endmodule

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [28:0] irq_req = '0;
  logic [3:0]  trap_req = '0;
  logic reg_wr = 0, retire = 0, iret = 0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic int_ack;
  logic [5:0]  int_vec;
  logic [23:0] int_addr;
  logic [3:0]  cpu_level;
  int checks = 0, fails = 0;
  logic [29:0] expq [$];

  always #2 clk = ~clk;

  irq_nest_ctrl u_dut (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_req(trap_req),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .retire(retire), .iret(iret), .int_ack(int_ack), .int_vec(int_vec),
    .int_addr(int_addr), .cpu_level(cpu_level));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && int_ack) begin
    if (expq.size() == 0) check(0, "R4 unexpected ack", {int_vec, int_addr}, 0);
    else begin
      logic [29:0] e;
      e = expq.pop_front();
      check({int_vec, int_addr} == e, "R4/R6 vector and address", {int_vec, int_addr}, e);
    end
  end

  task automatic push(input logic [5:0] v, input logic [23:0] a);
    expq.push_back({v, a});
  endtask
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #0.5;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask
  task automatic pulse(input logic [28:0] m);
    @(negedge clk); irq_req = m; @(negedge clk); irq_req = '0;
  endtask
  task automatic tpulse(input logic [3:0] m);
    @(negedge clk); trap_req = m; @(negedge clk); trap_req = '0;
  endtask
  task automatic ret();
    @(negedge clk); iret = 1; @(negedge clk); iret = 0;
  endtask
  task automatic ret_pulse();
    @(negedge clk); retire = 1; @(negedge clk); retire = 0;
  endtask
  task automatic settle(input string tag);
    repeat (5) @(negedge clk);
    check(expq.size() == 0, tag, expq.size(), 0);
  endtask
  task automatic lvl_chk(input logic [3:0] exp, input string tag);
    @(negedge clk);
    check(cpu_level == exp, tag, cpu_level, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", expq.size());
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    lvl_chk(0, "R1 level");
    check(int_ack == 0, "R1 ack", int_ack, 0);
    rd_chk(14, 16'h0000, "R1 control");
    rd_chk(6, 16'h0000, "R1 priority");
    wr(6, 16'h4531); wr(7, 16'h0003); wr(8, 16'h0760);
    // R2: flag latches while disabled, then enabling fires it
    pulse(29'h4);
    settle("R2 no ack while disabled");
    rd_chk(0, 16'h0004, "R2 flag set while disabled");
    push(10, 24'h000018);
    wr(3, 16'h0004);
    settle("R3 enable fires");
    lvl_chk(5, "R7 level raised");
    push(17, 24'h000026);
    wr(3, 16'h020C);
    pulse(29'h200);
    settle("R4 higher preempts");
    lvl_chk(6, "R7 nested level");
    pulse(29'h8);
    settle("R4 lower not taken");
    wr(0, 16'h0000);
    rd_chk(0, 16'h0000, "R2 software clear");
    ret(); lvl_chk(5, "R7 pop to 5");
    ret(); lvl_chk(0, "R7 pop to 0");
    ret(); lvl_chk(0, "R7 empty return ignored");
    // R5 tie: sources 1 and 4 both at level 3
    wr(3, 16'h0012);
    push(9, 24'h000016);
    pulse(29'h12);
    settle("R5 tie lowest vector");
    wr(0, 16'h0000); ret();
    // R3 priority 0
    wr(3, 16'h0020);
    pulse(29'h20);
    settle("R3 priority zero silent");
    rd_chk(0, 16'h0020, "R3 flag present yet silent");
    wr(0, 16'h0000);
    // R8/R9 nesting disable
    wr(3, 16'h0202);
    wr(14, 16'h8000);
    wr(14, 16'h8005);
    rd_chk(14, 16'h8000, "R9 level write frozen");
    push(9, 24'h000016);
    pulse(29'h2);
    settle("R8 first accepted");
    pulse(29'h200);
    settle("R8 nested blocked");
    push(1, 24'h000006);
    tpulse(4'h2);
    settle("R8 trap still accepted");
    lvl_chk(10, "R5 trap level");
    wr(0, 16'h0000);
    ret(); lvl_chk(3, "R7 pop after trap");
    ret();
    wr(14, 16'h0000);
    wr(14, 16'h0002);
    rd_chk(14, 16'h0002, "R9 level writable");
    wr(14, 16'h0000);
    // R10 window
    wr(3, 16'h0600);
    wr(15, 16'h0003);
    rd_chk(14, 16'h4000, "R10 window active");
    pulse(29'h200);
    settle("R10 level 6 masked");
    push(18, 24'h000028);
    pulse(29'h400);
    settle("R10 level 7 passes");
    ret_pulse(); ret_pulse();
    rd_chk(14, 16'h4007, "R10 still active");
    wr(15, 16'h0002);
    ret_pulse();
    rd_chk(14, 16'h4007, "R10 reload restarts");
    ret_pulse();
    rd_chk(14, 16'h0007, "R10 window over");
    wr(0, 16'h0200);
    push(17, 24'h000026);
    ret();
    settle("R10 masked source taken later");
    lvl_chk(6, "R7 level after retake");
    wr(0, 16'h0000); ret();
    // R6 alternate table
    wr(14, 16'h2000);
    wr(3, 16'h0001);
    push(8, 24'h000094);
    pulse(29'h1);
    settle("R6 alternate base");
    wr(0, 16'h0000); ret();
    wr(14, 16'h0000);
    // R5 trap ranking
    push(0, 24'h000004);
    tpulse(4'h9);
    settle("R5 lowest trap first");
    push(3, 24'h00000A);
    ret();
    settle("R5 second trap after return");
    lvl_chk(8, "R5 trap 3 level");
    ret(); lvl_chk(0, "R7 final pop");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule